// File: doc/BRIEF.md
# NRZI Serial-to-Symbol Deserializer with Loopback

This block turns a serial NRZI bit stream into parallel 5-bit symbols. It runs entirely on one bit-rate clock, which is taken to be already recovered. Each clock it picks one serial bit, decodes it from NRZI to NRZ, and shifts the result into a symbol register. A free-running modulo-5 counter sets symbol alignment. Each time the counter wraps, the block issues a one-cycle symbol-rate enable and presents the finished symbol. With a 125 Mbit/s line, that enable runs at 25 MHz.

A source select, active low, switches the serial input. It chooses either the external line or the serial stream of the local transmitter, which gives a loopback path. A signal-detect input qualifies line data. While line data is unqualified, the block clears its NRZI history and its partial symbol. A symbol that took in any unqualified bit is marked invalid and is presented as zero. In loopback, signal-detect has no effect.

Top module: `nrzi_sym_deser`

## Requirements
- R1: Each decoded bit is 1 when the selected serial bit differs from the previously accepted serial bit, and 0 otherwise; the history starts at 0.
- R2: The first bit of a symbol lands in bit 4 (the MSB) of `sym_o` and the fifth bit lands in bit 0.
- R3: `sym_ce_o` is high for exactly one cycle in every 5. Its first pulse follows the fifth rising edge after reset is released.
- R4: With `lpbk_n_i` high and `sig_det_i` low, the bit is unqualified: the NRZI history and the partial symbol are forced to 0. The next qualified bit is then decoded against a history of 0.
- R5: `sym_vld_o` pulses together with `sym_ce_o` only if all 5 bits of that symbol were qualified. Otherwise it stays low.
- R6: When a symbol completes and is invalid, `sym_o` shows 0 from that `sym_ce_o` cycle onward.
- R7: `sym_o` changes only in cycles where `sym_ce_o` is high, and it holds between those pulses.
- R8: With `lpbk_n_i` low, the block takes its bits from `tx_ser_i`. In this mode `line_i` and `sig_det_i` have no effect on the result.
- R9: A synchronous active-high `rst` clears the alignment counter, the history, the shift register, `sym_o`, `sym_vld_o` and `sym_ce_o`. Symbol alignment restarts at the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Serial NRZI data from the line |
| sig_det_i | input | 1 | Line signal present; qualifies `line_i` |
| lpbk_n_i | input | 1 | Source select: 1 = line, 0 = loopback from `tx_ser_i` |
| tx_ser_i | input | 1 | Serial NRZI stream from the local transmitter |
| sym_o | output | 5 | Last completed symbol, first bit in MSB |
| sym_vld_o | output | 1 | One-cycle pulse: `sym_o` holds a fully qualified symbol |
| sym_ce_o | output | 1 | Symbol-rate enable, bit clock divided by 5 |

## Verification
Some properties hold on every cycle and are checked by assertions: the enable is a single-cycle pulse, valid pulses occur only with the enable, the symbol output holds between enables, an invalid completed symbol reads zero, and an unqualified bit suppresses the next valid pulse. Other behaviour can only be shown by directed scenarios, because it needs a bench-side encoder to know the expected value. This covers the NRZI decode values, MSB-first bit placement, the clearing of history after signal loss, loopback ignoring the line, and realignment after a mid-symbol reset.

// File: rtl/nrzi_deser_pkg.sv
package nrzi_deser_pkg;

    // Serial source chosen by the active-low loopback select
    typedef enum logic {
        SRC_LINE = 1'b0,
        SRC_LOOP = 1'b1
    } ser_src_e;

    // Width of a counter that spans 0..n-1, at least 1 bit
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/nrzi_src_sel.sv
module nrzi_src_sel (
    input  logic line_i,
    input  logic tx_ser_i,
    input  logic lpbk_n_i,
    input  logic sig_det_i,
    output logic bit_o,
    output logic qual_o
);
    import nrzi_deser_pkg::*;

    ser_src_e src;

    always_comb begin
        src = lpbk_n_i ? SRC_LINE : SRC_LOOP;
        unique case (src)
            SRC_LOOP: begin
                bit_o  = tx_ser_i;
                qual_o = 1'b1;      // loopback never waits on signal detect
            end
            default: begin
                bit_o  = line_i;
                qual_o = sig_det_i;
            end
        endcase
    end

endmodule

// File: rtl/nrzi_bit_dec.sv
module nrzi_bit_dec (
    input  logic bit_i,
    input  logic qual_i,
    input  logic hist_i,
    output logic nrz_o,
    output logic hist_next_o
);
    always_comb begin
        if (qual_i) begin
            nrz_o       = bit_i ^ hist_i;
            hist_next_o = bit_i;
        end else begin
            nrz_o       = 1'b0;
            hist_next_o = 1'b0;
        end
    end
endmodule

// File: rtl/nrzi_sym_counter.sv
module nrzi_sym_counter #(
    parameter int N = 5
) (
    input  logic clk,
    input  logic rst,
    output logic last_o
);
    import nrzi_deser_pkg::*;

    localparam int CW = cnt_width(N);
    localparam logic [CW-1:0] LAST_VAL = CW'(N - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last_o = (cnt_q == LAST_VAL);
        cnt_d  = last_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/nrzi_sym_deser.sv
module nrzi_sym_deser #(
    parameter int SYM_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic             sig_det_i,
    input  logic             lpbk_n_i,
    input  logic             tx_ser_i,
    output logic [SYM_W-1:0] sym_o,
    output logic             sym_vld_o,
    output logic             sym_ce_o
);

    typedef struct packed {
        logic             hist;
        logic [SYM_W-1:0] shreg;
        logic [SYM_W-1:0] sym;
        logic             vld;
        logic             ce;
        logic             clean;   // every bit of the current symbol qualified
    } st_t;

    localparam st_t ST_RST = '{hist: 1'b0, shreg: '0, sym: '0,
                               vld: 1'b0, ce: 1'b0, clean: 1'b1};

    st_t  st_d, st_q;
    logic ser_bit, ser_qual, nrz_bit, hist_nx, sym_last;
    logic [SYM_W-1:0] shreg_nx;

    nrzi_src_sel u_sel (
        .line_i    (line_i),
        .tx_ser_i  (tx_ser_i),
        .lpbk_n_i  (lpbk_n_i),
        .sig_det_i (sig_det_i),
        .bit_o     (ser_bit),
        .qual_o    (ser_qual)
    );

    nrzi_bit_dec u_dec (
        .bit_i       (ser_bit),
        .qual_i      (ser_qual),
        .hist_i      (st_q.hist),
        .nrz_o       (nrz_bit),
        .hist_next_o (hist_nx)
    );

    nrzi_sym_counter #(.N(SYM_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .last_o (sym_last)
    );

    generate
        if (SYM_W > 1) begin : g_shift
            assign shreg_nx = {st_q.shreg[SYM_W-2:0], nrz_bit};
        end else begin : g_single
            assign shreg_nx = nrz_bit;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.hist = hist_nx;
        st_d.ce   = sym_last;
        st_d.vld  = 1'b0;
        if (ser_qual) st_d.shreg = shreg_nx;
        else          st_d.shreg = '0;

        if (sym_last) begin
            st_d.clean = 1'b1;
            if (st_q.clean && ser_qual) begin
                st_d.sym = shreg_nx;
                st_d.vld = 1'b1;
            end else begin
                st_d.sym = '0;
            end
        end else begin
            st_d.clean = st_q.clean & ser_qual;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RST;
        else     st_q <= st_d;
    end

    assign sym_o     = st_q.sym;
    assign sym_vld_o = st_q.vld;
    assign sym_ce_o  = st_q.ce;

endmodule

// File: rtl/nrzi_sym_deser_chk.sv
module nrzi_sym_deser_chk #(
    parameter int SYM_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             sig_det_i,
    input logic             lpbk_n_i,
    input logic [SYM_W-1:0] sym_o,
    input logic             sym_vld_o,
    input logic             sym_ce_o
);

    // R3: enable is a single-cycle pulse
    p_ce_single_r3: assert property (@(posedge clk) disable iff (rst)
        sym_ce_o |=> !sym_ce_o);

    // R5: valid only alongside the symbol enable
    p_vld_with_ce_r5: assert property (@(posedge clk) disable iff (rst)
        sym_vld_o |-> sym_ce_o);

    // R4: an unqualified line bit prevents the next valid pulse
    p_unqual_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (lpbk_n_i && !sig_det_i) |=> !sym_vld_o);

    // R6: invalid completed symbol reads zero
    p_invalid_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (sym_ce_o && !sym_vld_o) |-> (sym_o == '0));

    // R7: symbol output holds between enables
    p_sym_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !sym_ce_o |-> $stable(sym_o));

endmodule

bind nrzi_sym_deser nrzi_sym_deser_chk #(.SYM_W(SYM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sig_det_i (sig_det_i),
    .lpbk_n_i  (lpbk_n_i),
    .sym_o     (sym_o),
    .sym_vld_o (sym_vld_o),
    .sym_ce_o  (sym_ce_o)
);

// File: tb/nrzi_sym_deser_tb.sv
module nrzi_sym_deser_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         line_i = 1'b0, sig_det_i = 1'b0, lpbk_n_i = 1'b1, tx_ser_i = 1'b0;
    logic [W-1:0] sym_o;
    logic         sym_vld_o, sym_ce_o;

    int n_chk = 0, n_bad = 0;
    logic         prev = 1'b0;      // last accepted serial level
    logic [W-1:0] last_sym = '0;    // bench copy of expected sym_o

    always #(CLK_PERIOD/2) clk = ~clk;

    nrzi_sym_deser #(.SYM_W(W)) u_dut (
        .clk(clk), .rst(rst), .line_i(line_i), .sig_det_i(sig_det_i),
        .lpbk_n_i(lpbk_n_i), .tx_ser_i(tx_ser_i),
        .sym_o(sym_o), .sym_vld_o(sym_vld_o), .sym_ce_o(sym_ce_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sends one symbol MSB first; lb selects loopback; sd gives sig_det per bit (bit 4 first)
    task automatic send_sym(input logic [W-1:0] s, input logic lb,
                            input logic [W-1:0] sd, input string tag);
        logic ok = 1'b1;
        logic exp_v;
        for (int i = W - 1; i >= 0; i--) begin
            logic q, lvl;
            q = lb | sd[i];
            lpbk_n_i  = ~lb;
            sig_det_i = sd[i];
            lvl = q ? (prev ^ s[i]) : ~prev;
            if (lb) begin tx_ser_i = lvl; line_i = $urandom_range(1); end
            else    begin line_i = lvl;   tx_ser_i = $urandom_range(1); end
            prev = q ? lvl : 1'b0;
            ok   = ok & q;
            @(negedge clk);
            if (i == W - 1) begin
                // R3/R7 between pulses: no enable, output held
                check({tag, " R3 ce low mid-symbol"}, sym_ce_o, 0);
                check({tag, " R7 sym held"}, sym_o, last_sym);
            end
        end
        exp_v = ok;
        last_sym = exp_v ? s : '0;
        check({tag, " R3 ce at wrap"}, sym_ce_o, 1);
        check({tag, " R5 vld"}, sym_vld_o, exp_v);
        check({tag, exp_v ? " R2 sym" : " R6 sym zero"}, sym_o, last_sym);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        prev = 1'b0;
        last_sym = '0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R9 reset sym", sym_o, 0);
        check("R9 reset vld", sym_vld_o, 0);
        check("R9 reset ce", sym_ce_o, 0);
    endtask

    task automatic t_line();
        send_sym(5'b10110, 1'b0, '1, "line A R1");
        send_sym(5'b00000, 1'b0, '1, "line B R1");
        send_sym(5'b11111, 1'b0, '1, "line C R1");
        send_sym(5'b10000, 1'b0, '1, "line D R2");
        send_sym(5'b00001, 1'b0, '1, "line E R2");
    endtask

    task automatic t_sigdet();
        send_sym(5'b11011, 1'b0, 5'b11011, "loss R4");
        send_sym(5'b01101, 1'b0, '1,       "after loss R4");
        send_sym(5'b11100, 1'b0, 5'b11110, "loss last bit R4");
        send_sym(5'b10101, 1'b0, '1,       "recover R4");
    endtask

    task automatic t_loopback();
        send_sym(5'b01110, 1'b1, '0, "loop R8");
        send_sym(5'b11001, 1'b1, '0, "loop R8");
        send_sym(5'b00111, 1'b0, '1, "back to line R8");
    endtask

    task automatic t_reset_mid();
        sig_det_i = 1'b1; lpbk_n_i = 1'b1;
        line_i = ~line_i;
        @(negedge clk);
        line_i = ~line_i;
        @(negedge clk);
        do_reset();
        check("R9 mid reset sym", sym_o, 0);
        check("R9 mid reset ce", sym_ce_o, 0);
        send_sym(5'b11010, 1'b0, '1, "realign R9");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_line();
        t_sigdet();
        t_loopback();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R3 watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule